// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the entry part of interrupt handling for a 16-bit processor with segmented memory. It watches three request sources: an unmaskable request strobe, software or exception request strobes that carry an 8-bit vector type, and a level-sensitive maskable request whose type byte is supplied alongside it. When the core signals that the current instruction has completed, the sequencer picks the highest-priority request that is pending. It saves the processor context onto the stack through a byte-wide memory port. It then loads the new instruction pointer and code segment from the vector table and returns the flag image the handler will start with.

The sequencer captures the flags, code segment, instruction pointer, stack segment and stack pointer when it accepts a request. It then writes three words to the stack, two bytes each, with the high byte first. After each word it reports the decremented stack pointer. Next it reads four bytes from the vector table and raises `done` for one cycle. While `done` is high, `new_ip`, `new_cs` and `new_flags` hold the handler entry state. The sequencer waits on every memory access until the memory answers.

States: `ST_IDLE` waits for a boundary with a granted request. `ST_PUSH_HI` writes the high byte of the current word. `ST_PUSH_LO` writes its low byte. `ST_VEC_RD` reads the four vector bytes. `ST_DONE` presents the result. Transitions: IDLE→PUSH_HI on boundary and grant. PUSH_HI→PUSH_LO on ready. PUSH_LO→PUSH_HI on ready while words remain. PUSH_LO→VEC_RD on ready after the third word. VEC_RD→DONE on ready for the fourth byte. DONE→IDLE unconditionally. A state with no ready holds itself.

Top module: `isr_entry_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `done`, `mem_valid` and `sp_wr` are all 0.
- R2: A request is accepted only in a cycle where `insn_boundary` is 1. A strobed request that arrives while `insn_boundary` is 0 stays pending, and no memory access happens until a boundary occurs.
- R3: The context is pushed as flags, then code segment, then instruction pointer. Each word writes its high byte at offset SP−1 and then its low byte at offset SP−2. SP is the value in force before that word. The physical address is stack segment × 16 plus the 16-bit offset, taken modulo 2^20, and the offset wraps within 64 KiB.
- R4: After the pushes, four byte reads fetch the vector at physical addresses type×4, type×4+1, type×4+2 and type×4+3, in that order. The first two bytes form the new instruction pointer and the last two form the new code segment, low byte first. Every read falls within 00000h–003FFh.
- R5: `new_flags` equals the captured flags with bit 9 (interrupt enable) and bit 8 (trap) cleared and all other bits unchanged. The pushed flag word is the captured flags, unmodified.
- R6: An unmaskable request is taken even when flag bit 9 is 0, and it always uses vector type 2.
- R7: The maskable request is level-sensitive and has no effect while `flags_in` bit 9 is 0. When bit 9 is 1, it is taken with the type on `intr_type`, which may be any value from 00h to FFh.
- R8: When several requests are pending at one boundary, the sequencer takes the unmaskable request first, then the software request, then the maskable request. Untaken requests remain pending and are served at later boundaries.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, the sequencer holds the access with address, write enable and write data unchanged. Each access takes exactly as many cycles as the memory delays it.
- R10: `sp_wr` pulses once after each completed word push, with `sp_wdata` equal to the new SP. After the third push SP is the starting SP minus 6.
- R11: `done` is high for exactly one cycle, in the cycle after the fourth vector read completes. With a memory that never stalls, an entry occupies 11 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_boundary | input | 1 | Current instruction has completed |
| nmi_req | input | 1 | Unmaskable request strobe |
| soft_req | input | 1 | Software or exception request strobe |
| soft_type | input | 8 | Vector type for the software request |
| intr_req | input | 1 | Maskable request level |
| intr_type | input | 8 | Vector type for the maskable request |
| flags_in | input | 16 | Current flag word (bit 9 interrupt enable, bit 8 trap) |
| ss_in | input | 16 | Current stack segment |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| mem_valid | output | 1 | Memory byte access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with ready |
| mem_ready | input | 1 | Memory completes the access this cycle |
| sp_wr | output | 1 | Stack pointer update strobe |
| sp_wdata | output | 16 | New stack pointer value |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Entry complete, results valid |
| new_ip | output | 16 | Handler instruction pointer |
| new_cs | output | 16 | Handler code segment |
| new_flags | output | 16 | Flag word for the handler |

## Verification
The bench builds the block with its default parameters: a 20-bit physical address, 16-bit words, a segment shift of 4, interrupt enable at bit 9, trap at bit 8 and unmaskable type 2. With these values it can place a stack segment of FFFFh and a stack pointer of 0001h, which drives both the 64 KiB offset wrap and the 1 MiB physical wrap. It can also use type FFh to reach the top entry of the vector table. The bench's memory model has a configurable stall, so it runs entries with zero wait and with three wait cycles per byte.

// File: rtl/isr_entry_pkg.sv
package isr_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_VEC_RD,
        ST_DONE
    } ent_state_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_SOFT,
        SRC_INTR
    } req_src_t;

    localparam int unsigned PUSH_WORDS = 3;
    localparam int unsigned VEC_BYTES  = 4;
    localparam int unsigned BYTE_W     = 8;

endpackage

// File: rtl/isr_req_arbiter.sv
module isr_req_arbiter
    import isr_entry_pkg::*;
#(
    parameter int unsigned TYPE_W = 8,
    parameter logic [TYPE_W-1:0] NMI_TYPE = TYPE_W'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic              soft_req,
    input  logic [TYPE_W-1:0] soft_type,
    input  logic              intr_req,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic              int_enable,
    input  logic              take,
    output logic              grant_vld,
    output logic [TYPE_W-1:0] grant_type,
    output req_src_t          grant_src
);

    logic              nmi_pend;
    logic              soft_pend;
    logic [TYPE_W-1:0] soft_type_q;

    // Strobed sources are held until served; a new strobe re-arms them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_pend    <= 1'b0;
            soft_pend   <= 1'b0;
            soft_type_q <= '0;
        end else begin
            nmi_pend  <= (nmi_pend  && !(take && grant_src == SRC_NMI))  || nmi_req;
            soft_pend <= (soft_pend && !(take && grant_src == SRC_SOFT)) || soft_req;
            if (soft_req) begin
                soft_type_q <= soft_type;
            end
        end
    end

    // Fixed priority: unmaskable, software, maskable (gated by enable flag).
    always_comb begin
        grant_vld  = 1'b0;
        grant_type = '0;
        grant_src  = SRC_NONE;
        if (nmi_pend) begin
            grant_vld  = 1'b1;
            grant_type = NMI_TYPE;
            grant_src  = SRC_NMI;
        end else if (soft_pend) begin
            grant_vld  = 1'b1;
            grant_type = soft_type_q;
            grant_src  = SRC_SOFT;
        end else if (intr_req && int_enable) begin
            grant_vld  = 1'b1;
            grant_type = intr_type;
            grant_src  = SRC_INTR;
        end
    end

endmodule

// File: rtl/isr_addr_gen.sv
module isr_addr_gen
    import isr_entry_pkg::*;
#(
    parameter int unsigned PADDR_W   = 20,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned SEG_SHIFT = 4,
    parameter int unsigned TYPE_W    = 8
) (
    input  logic               is_push,
    input  logic               is_hi,
    input  logic [OFF_W-1:0]   seg,
    input  logic [OFF_W-1:0]   sp,
    input  logic [TYPE_W-1:0]  vec_type,
    input  logic [1:0]         byte_idx,
    input  logic [OFF_W-1:0]   push_word,
    output logic [PADDR_W-1:0] addr,
    output logic [BYTE_W-1:0]  wdata
);

    localparam logic [OFF_W-1:0] HI_DEC = OFF_W'(1);
    localparam logic [OFF_W-1:0] LO_DEC = OFF_W'(2);

    logic [OFF_W-1:0]   stk_off;
    logic [PADDR_W-1:0] seg_base;
    logic [PADDR_W-1:0] stk_addr;
    logic [PADDR_W-1:0] vec_addr;

    always_comb begin
        // Offset arithmetic stays inside the segment (wraps at OFF_W bits).
        stk_off  = sp - (is_hi ? HI_DEC : LO_DEC);
        seg_base = PADDR_W'({seg, {SEG_SHIFT{1'b0}}});
        stk_addr = seg_base + PADDR_W'(stk_off);
        vec_addr = PADDR_W'({vec_type, byte_idx});
        addr     = is_push ? stk_addr : vec_addr;
        wdata    = is_hi ? push_word[OFF_W-1 -: BYTE_W] : push_word[BYTE_W-1:0];
    end

endmodule

// File: rtl/isr_entry_fsm.sv
module isr_entry_fsm
    import isr_entry_pkg::*;
#(
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned TYPE_W = 8,
    parameter int unsigned IF_POS = 9,
    parameter int unsigned TF_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              grant_vld,
    input  logic [TYPE_W-1:0] grant_type,
    input  logic [OFF_W-1:0]  flags_in,
    input  logic [OFF_W-1:0]  seg_in,
    input  logic [OFF_W-1:0]  cs_in,
    input  logic [OFF_W-1:0]  ip_in,
    input  logic [OFF_W-1:0]  sp_in,
    input  logic              mem_ready,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              take,
    output logic              is_push,
    output logic              is_hi,
    output logic              is_read,
    output logic              busy,
    output logic              done,
    output logic [OFF_W-1:0]  cur_seg,
    output logic [OFF_W-1:0]  cur_sp,
    output logic [OFF_W-1:0]  push_word,
    output logic [TYPE_W-1:0] cur_type,
    output logic [1:0]        byte_idx,
    output logic              sp_wr,
    output logic [OFF_W-1:0]  sp_wdata,
    output logic [OFF_W-1:0]  new_ip,
    output logic [OFF_W-1:0]  new_cs,
    output logic [OFF_W-1:0]  new_flags
);

    localparam logic [1:0] LAST_WORD = 2'(PUSH_WORDS - 1);
    localparam logic [1:0] LAST_BYTE = 2'(VEC_BYTES - 1);
    localparam logic [OFF_W-1:0] CLR_MASK =
        ~((OFF_W'(1) << IF_POS) | (OFF_W'(1) << TF_POS));

    ent_state_t       state;
    ent_state_t       nxt;
    logic [1:0]       word_idx;
    logic [OFF_W-1:0] img_flags;
    logic [OFF_W-1:0] img_cs;
    logic [OFF_W-1:0] img_ip;
    logic [BYTE_W-1:0] vec_b [VEC_BYTES];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (boundary && grant_vld) nxt = ST_PUSH_HI;
            ST_PUSH_HI: if (mem_ready) nxt = ST_PUSH_LO;
            ST_PUSH_LO: if (mem_ready) nxt = (word_idx == LAST_WORD) ? ST_VEC_RD : ST_PUSH_HI;
            ST_VEC_RD:  if (mem_ready && byte_idx == LAST_BYTE) nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Decoded outputs
    always_comb begin
        take    = (state == ST_IDLE) && boundary && grant_vld;
        is_push = (state == ST_PUSH_HI) || (state == ST_PUSH_LO);
        is_hi   = (state == ST_PUSH_HI);
        is_read = (state == ST_VEC_RD);
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        unique case (word_idx)
            2'd0:    push_word = img_flags;
            2'd1:    push_word = img_cs;
            default: push_word = img_ip;
        endcase
    end

    // Context capture, SP tracking and vector assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx  <= '0;
            byte_idx  <= '0;
            cur_type  <= '0;
            cur_seg   <= '0;
            cur_sp    <= '0;
            img_flags <= '0;
            img_cs    <= '0;
            img_ip    <= '0;
            sp_wr     <= 1'b0;
            sp_wdata  <= '0;
            new_ip    <= '0;
            new_cs    <= '0;
            new_flags <= '0;
            for (int i = 0; i < VEC_BYTES; i++) begin
                vec_b[i] <= '0;
            end
        end else begin
            sp_wr <= 1'b0;
            if (take) begin
                cur_type  <= grant_type;
                cur_seg   <= seg_in;
                cur_sp    <= sp_in;
                img_flags <= flags_in;
                img_cs    <= cs_in;
                img_ip    <= ip_in;
                word_idx  <= '0;
                byte_idx  <= '0;
            end
            if (state == ST_PUSH_LO && mem_ready) begin
                cur_sp   <= cur_sp - OFF_W'(2);
                sp_wdata <= cur_sp - OFF_W'(2);
                sp_wr    <= 1'b1;
                word_idx <= word_idx + 2'd1;
            end
            if (state == ST_VEC_RD && mem_ready) begin
                vec_b[byte_idx] <= mem_rdata;
                byte_idx        <= byte_idx + 2'd1;
                if (byte_idx == LAST_BYTE) begin
                    new_ip    <= OFF_W'({vec_b[1], vec_b[0]});
                    new_cs    <= OFF_W'({mem_rdata, vec_b[2]});
                    new_flags <= img_flags & CLR_MASK;
                end
            end
        end
    end

endmodule

// File: rtl/isr_entry_seq.sv
module isr_entry_seq
    import isr_entry_pkg::*;
#(
    parameter int unsigned PADDR_W   = 20,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned SEG_SHIFT = 4,
    parameter int unsigned TYPE_W    = 8,
    parameter int unsigned IF_POS    = 9,
    parameter int unsigned TF_POS    = 8,
    parameter logic [TYPE_W-1:0] NMI_TYPE = TYPE_W'(2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_boundary,
    input  logic               nmi_req,
    input  logic               soft_req,
    input  logic [TYPE_W-1:0]  soft_type,
    input  logic               intr_req,
    input  logic [TYPE_W-1:0]  intr_type,
    input  logic [OFF_W-1:0]   flags_in,
    input  logic [OFF_W-1:0]   ss_in,
    input  logic [OFF_W-1:0]   cs_in,
    input  logic [OFF_W-1:0]   ip_in,
    input  logic [OFF_W-1:0]   sp_in,
    output logic               mem_valid,
    output logic               mem_we,
    output logic [PADDR_W-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_ready,
    output logic               sp_wr,
    output logic [OFF_W-1:0]   sp_wdata,
    output logic               busy,
    output logic               done,
    output logic [OFF_W-1:0]   new_ip,
    output logic [OFF_W-1:0]   new_cs,
    output logic [OFF_W-1:0]   new_flags
);

    logic              grant_vld;
    logic [TYPE_W-1:0] grant_type;
    req_src_t          grant_src;
    logic              take;
    logic              is_push;
    logic              is_hi;
    logic              is_read;
    logic [OFF_W-1:0]  cur_seg;
    logic [OFF_W-1:0]  cur_sp;
    logic [OFF_W-1:0]  push_word;
    logic [TYPE_W-1:0] cur_type;
    logic [1:0]        byte_idx;

    isr_req_arbiter #(
        .TYPE_W   (TYPE_W),
        .NMI_TYPE (NMI_TYPE)
    ) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_req    (nmi_req),
        .soft_req   (soft_req),
        .soft_type  (soft_type),
        .intr_req   (intr_req),
        .intr_type  (intr_type),
        .int_enable (flags_in[IF_POS]),
        .take       (take),
        .grant_vld  (grant_vld),
        .grant_type (grant_type),
        .grant_src  (grant_src)
    );

    isr_entry_fsm #(
        .OFF_W  (OFF_W),
        .TYPE_W (TYPE_W),
        .IF_POS (IF_POS),
        .TF_POS (TF_POS)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (insn_boundary),
        .grant_vld  (grant_vld),
        .grant_type (grant_type),
        .flags_in   (flags_in),
        .seg_in     (ss_in),
        .cs_in      (cs_in),
        .ip_in      (ip_in),
        .sp_in      (sp_in),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .take       (take),
        .is_push    (is_push),
        .is_hi      (is_hi),
        .is_read    (is_read),
        .busy       (busy),
        .done       (done),
        .cur_seg    (cur_seg),
        .cur_sp     (cur_sp),
        .push_word  (push_word),
        .cur_type   (cur_type),
        .byte_idx   (byte_idx),
        .sp_wr      (sp_wr),
        .sp_wdata   (sp_wdata),
        .new_ip     (new_ip),
        .new_cs     (new_cs),
        .new_flags  (new_flags)
    );

    isr_addr_gen #(
        .PADDR_W   (PADDR_W),
        .OFF_W     (OFF_W),
        .SEG_SHIFT (SEG_SHIFT),
        .TYPE_W    (TYPE_W)
    ) agen_i (
        .is_push   (is_push),
        .is_hi     (is_hi),
        .seg       (cur_seg),
        .sp        (cur_sp),
        .vec_type  (cur_type),
        .byte_idx  (byte_idx),
        .push_word (push_word),
        .addr      (mem_addr),
        .wdata     (mem_wdata)
    );

    assign mem_valid = is_push || is_read;
    assign mem_we    = is_push;

endmodule

// File: rtl/isr_entry_chk.sv
module isr_entry_chk #(
    parameter int unsigned PADDR_W   = 20,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned IF_POS    = 9,
    parameter int unsigned TF_POS    = 8,
    parameter int unsigned VEC_LIMIT = 1024
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic               mem_we,
    input logic [PADDR_W-1:0] mem_addr,
    input logic [7:0]         mem_wdata,
    input logic               done,
    input logic               busy,
    input logic               sp_wr,
    input logic [OFF_W-1:0]   new_flags
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid && !done);  // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));  // R9

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_we |-> mem_addr < PADDR_W'(VEC_LIMIT));  // R4

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !new_flags[IF_POS] && !new_flags[TF_POS]);  // R5

    AST_SP_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr |-> $past(mem_valid && mem_ready && mem_we));  // R10

    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_valid && mem_ready && !mem_we));  // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R11

endmodule

bind isr_entry_seq isr_entry_chk #(
    .PADDR_W (PADDR_W),
    .OFF_W   (OFF_W),
    .IF_POS  (IF_POS),
    .TF_POS  (TF_POS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .busy      (busy),
    .sp_wr     (sp_wr),
    .new_flags (new_flags)
);

// File: tb/isr_entry_seq_tb_top.sv
module isr_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        nmi_req = 1'b0;
    logic        soft_req = 1'b0;
    logic [7:0]  soft_type = 8'h00;
    logic        intr_req = 1'b0;
    logic [7:0]  intr_type = 8'h00;
    logic [15:0] flags_in = 16'h0000;
    logic [15:0] ss_in = 16'h0000;
    logic [15:0] cs_in = 16'h0000;
    logic [15:0] ip_in = 16'h0000;
    logic [15:0] sp_in = 16'h0000;
    logic        mem_valid;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_ready = 1'b0;
    logic        sp_wr;
    logic [15:0] sp_wdata;
    logic        busy;
    logic        done;
    logic [15:0] new_ip;
    logic [15:0] new_cs;
    logic [15:0] new_flags;

    always #5 clk = ~clk;

    isr_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
        .nmi_req(nmi_req), .soft_req(soft_req), .soft_type(soft_type),
        .intr_req(intr_req), .intr_type(intr_type), .flags_in(flags_in),
        .ss_in(ss_in), .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .sp_wr(sp_wr), .sp_wdata(sp_wdata), .busy(busy), .done(done),
        .new_ip(new_ip), .new_cs(new_cs), .new_flags(new_flags)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  mem [int];
    logic [19:0] wr_a [16];
    logic [7:0]  wr_d [16];
    logic [19:0] rd_a [16];
    int          wr_n = 0;
    int          rd_n = 0;
    int          sp_n = 0;
    logic [15:0] last_sp = 16'h0000;
    int          stall = 0;
    int          wcnt = 0;

    // Memory model and monitors, all on the falling edge.
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
        if (mem_valid) begin
            if (wcnt >= stall) begin
                mem_ready = 1'b1;
                if (mem_we) begin
                    mem[int'(mem_addr)] = mem_wdata;
                    if (wr_n < 16) begin
                        wr_a[wr_n] = mem_addr;
                        wr_d[wr_n] = mem_wdata;
                    end
                    wr_n++;
                end else begin
                    mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
                    if (rd_n < 16) rd_a[rd_n] = mem_addr;
                    rd_n++;
                end
            end else begin
                wcnt++;
            end
        end
        if (sp_wr) begin
            sp_n++;
            last_sp = sp_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
        return {seg, 4'h0} + {4'h0, off};
    endfunction

    task automatic clear_logs();
        wr_n = 0;
        rd_n = 0;
        sp_n = 0;
    endtask

    task automatic set_vec(input logic [7:0] typ, input logic [15:0] vip, input logic [15:0] vcs);
        int b;
        b = int'(typ) * 4;
        mem[b]     = vip[7:0];
        mem[b + 1] = vip[15:8];
        mem[b + 2] = vcs[7:0];
        mem[b + 3] = vcs[15:8];
    endtask

    // Waits for done (sampled at the falling edge); returns busy cycles seen.
    task automatic wait_done(output int cyc);
        bit seen;
        seen = 1'b0;
        cyc = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (busy) cyc++;
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
        chk(seen, "R11", "done seen", 32'(seen), 32'd1);
    endtask

    // Checks one completed entry against the bench-side inputs.
    task automatic check_entry(input logic [7:0] typ, input string treq,
                               input logic [15:0] eip, input logic [15:0] ecs);
        logic [15:0] img [3];
        logic [19:0] ea;
        logic [7:0]  ed;
        img[0] = flags_in;
        img[1] = cs_in;
        img[2] = ip_in;
        chk(wr_n == 6, "R3", "push byte count", 32'(wr_n), 32'd6);
        for (int k = 0; k < 6 && k < wr_n; k++) begin
            ea = phys(ss_in, sp_in - 16'(k + 1));
            ed = (k % 2 == 0) ? img[k / 2][15:8] : img[k / 2][7:0];
            chk(wr_a[k] == ea, "R3", "push address", 32'(wr_a[k]), 32'(ea));
            chk(wr_d[k] == ed, "R3", "push data", 32'(wr_d[k]), 32'(ed));
        end
        chk(rd_n == 4, "R4", "vector read count", 32'(rd_n), 32'd4);
        for (int k = 0; k < 4 && k < rd_n; k++) begin
            ea = 20'({typ, 2'b00}) + 20'(k);
            chk(rd_a[k] == ea, treq, "vector read address (R4)", 32'(rd_a[k]), 32'(ea));
        end
        chk(new_ip == eip, "R4", "new ip", 32'(new_ip), 32'(eip));
        chk(new_cs == ecs, "R4", "new cs", 32'(new_cs), 32'(ecs));
        chk(new_flags == (flags_in & 16'hFCFF), "R5", "new flags",
            32'(new_flags), 32'(flags_in & 16'hFCFF));
        chk(sp_n == 3, "R10", "sp update count", 32'(sp_n), 32'd3);
        chk(last_sp == sp_in - 16'd6, "R10", "final sp", 32'(last_sp), 32'(sp_in - 16'd6));
        chk(busy == 1'b1, "R11", "busy during done", 32'(busy), 32'd1);
        clear_logs();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_valid && !sp_wr, "R1", "outputs in reset",
            32'({busy, done, mem_valid, sp_wr}), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !mem_valid && !sp_wr, "R1", "outputs after reset",
            32'({busy, done, mem_valid, sp_wr}), 32'd0);
    endtask

    task automatic t_soft_and_boundary();
        int cyc;
        stall = 0;
        flags_in = 16'h0386; ss_in = 16'h3000; cs_in = 16'h1234; ip_in = 16'hABCD; sp_in = 16'h0100;
        set_vec(8'h21, 16'h5566, 16'h7788);
        clear_logs();
        soft_type = 8'h21; soft_req = 1'b1;
        @(negedge clk);
        soft_req = 1'b0;
        repeat (5) @(negedge clk);
        chk(!busy && !mem_valid && wr_n == 0, "R2", "no entry without boundary",
            32'({busy, mem_valid}), 32'd0);
        insn_boundary = 1'b1;
        wait_done(cyc);
        chk(cyc == 11, "R11", "busy cycles no stall", 32'(cyc), 32'd11);
        check_entry(8'h21, "R2", 16'h5566, 16'h7788);
        insn_boundary = 1'b0;
        @(negedge clk);
        chk(!done, "R11", "done single cycle", 32'(done), 32'd0);
    endtask

    task automatic t_nmi_unmasked();
        int cyc;
        flags_in = 16'h0100; ss_in = 16'h2000; cs_in = 16'h0F00; ip_in = 16'h0042; sp_in = 16'h8000;
        set_vec(8'h02, 16'h1111, 16'h2222);
        clear_logs();
        nmi_req = 1'b1; insn_boundary = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
        wait_done(cyc);
        check_entry(8'h02, "R6", 16'h1111, 16'h2222);
        insn_boundary = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_intr_mask();
        int cyc;
        flags_in = 16'h0000; ss_in = 16'h4000; cs_in = 16'hC000; ip_in = 16'h0010; sp_in = 16'hFFFE;
        set_vec(8'hFF, 16'hBEEF, 16'hCAFE);
        clear_logs();
        intr_type = 8'hFF; intr_req = 1'b1; insn_boundary = 1'b1;
        repeat (8) @(negedge clk);
        chk(!busy && wr_n == 0 && rd_n == 0, "R7", "masked intr ignored",
            32'({busy, 8'(wr_n)}), 32'd0);
        flags_in = 16'h0BD5;
        wait_done(cyc);
        check_entry(8'hFF, "R7", 16'hBEEF, 16'hCAFE);
        intr_req = 1'b0; insn_boundary = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_priority();
        int cyc;
        flags_in = 16'h0246; ss_in = 16'h1000; cs_in = 16'h0700; ip_in = 16'h0123; sp_in = 16'h0400;
        set_vec(8'h02, 16'h1111, 16'h2222);
        set_vec(8'h21, 16'h5566, 16'h7788);
        set_vec(8'h40, 16'h9A9B, 16'h9C9D);
        clear_logs();
        nmi_req = 1'b1; soft_req = 1'b1; soft_type = 8'h21;
        intr_req = 1'b1; intr_type = 8'h40;
        @(negedge clk);
        nmi_req = 1'b0; soft_req = 1'b0;
        repeat (2) @(negedge clk);
        insn_boundary = 1'b1;
        wait_done(cyc);
        check_entry(8'h02, "R8", 16'h1111, 16'h2222);
        wait_done(cyc);
        check_entry(8'h21, "R8", 16'h5566, 16'h7788);
        wait_done(cyc);
        check_entry(8'h40, "R8", 16'h9A9B, 16'h9C9D);
        insn_boundary = 1'b0; intr_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy, "R8", "no further entry", 32'(busy), 32'd0);
    endtask

    task automatic t_stall_wrap();
        int cyc;
        stall = 3;
        flags_in = 16'h0200; ss_in = 16'hFFFF; cs_in = 16'h5A5A; ip_in = 16'hA5A5; sp_in = 16'h0001;
        set_vec(8'h10, 16'h0F0F, 16'hF0F0);
        clear_logs();
        soft_type = 8'h10; soft_req = 1'b1;
        @(negedge clk);
        soft_req = 1'b0; insn_boundary = 1'b1;
        wait_done(cyc);
        chk(cyc == 41, "R9", "busy cycles with stall 3", 32'(cyc), 32'd41);
        chk(wr_a[1] == 20'h0FFEF, "R3", "offset and physical wrap", 32'(wr_a[1]), 32'h0FFEF);
        check_entry(8'h10, "R9", 16'h0F0F, 16'hF0F0);
        insn_boundary = 1'b0;
        stall = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_soft_and_boundary();
        t_nmi_unmasked();
        t_intr_mask();
        t_priority();
        t_stall_wrap();
        summary();
    end

endmodule